// File: doc/BRIEF.md
# ADC Window Limit Interrupt Checker

This block watches the result of an 8-bit successive-approximation conversion and raises a sticky interrupt flag when the result falls outside a window. The window is set by a high limit register and a low limit register. The check runs in two stages. When the sequencer reports that the top nibble is resolved, that nibble is compared with the top nibbles of the two limits. If the nibble is already out of range, the flag is raised before the conversion ends. Otherwise the block waits for the final strobe and compares the whole 8-bit result with both limits.

A conversion starts with a one-cycle start pulse. On that pulse both limits are copied into shadow registers, and the checks use only the shadow copies. The state machine has three states:

- `ST_IDLE`: no conversion in progress.
- `ST_NIB`: waiting for the nibble strobe.
- `ST_FULL`: the nibble was in range, so the block waits for the final strobe.

The transitions are:

- IDLE→NIB on start. A start pulse from any state also goes to NIB, which restarts the check.
- NIB→IDLE on the nibble strobe when the nibble is out of range. This is an early hit, and the final check is skipped.
- NIB→FULL on the nibble strobe when the nibble is in range.
- FULL→IDLE on the final strobe.

Software clears the flag by pulsing the clear input.

Top module: `blc_window_irq`

## Requirements
- R1: After reset the interrupt flag is 0 and the checker is idle.
- R2: The limits are copied on the start pulse. Limit input changes after that pulse do not affect the current conversion's result.
- R3: At the nibble strobe, the result's bits [7:4] are compared with bits [7:4] of each limit. If the nibble is greater than the high nibble or less than the low nibble, and the enable is 1, the flag reads 1 from the cycle after the strobe.
- R4: If the nibble is in range, the full 8-bit result is compared at the final strobe. The flag is set when the result is greater than the high limit or less than the low limit.
- R5: A result, or a nibble, equal to a limit counts as inside the window.
- R6: After an early hit, the final strobe of that conversion sets nothing. At most one flag set happens per conversion.
- R7: While the enable is 0, no check sets the flag.
- R8: The flag stays 1 until the clear input is 1. A new start pulse does not clear it.
- R9: When a set and a clear happen in the same cycle, the set wins.
- R10: Strobes that arrive while the checker is idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Start-of-conversion pulse; copies the limits |
| lim_hi | input | 8 | High limit |
| lim_lo | input | 8 | Low limit |
| chk_en | input | 1 | Limit check enable |
| res_data | input | 8 | Partial or final result; the top nibble is valid at the nibble strobe |
| nib_stb | input | 1 | Top nibble resolved |
| done_stb | input | 1 | All bits resolved |
| irq_clr | input | 1 | Write-one clear of the flag |
| irq_flag | output | 1 | Sticky out-of-window flag |

## Verification
The bench builds the block with its default parameters: an 8-bit result and a 4-bit early-check nibble. With these values every boundary case can be written as a short hex vector. The cases include:

- a nibble equal to a limit nibble, where the decision falls through to the full compare;
- a full result one step above or below a limit;
- a result exactly equal to a limit.

Directed runs then cover:

- limit changes during a conversion;
- the skip after an early hit;
- a set and a clear landing in the same cycle;
- strobes while idle.

// File: rtl/blc_pkg.sv
package blc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NIB  = 2'd1,
        ST_FULL = 2'd2
    } blc_state_e;
endpackage

// File: rtl/blc_cmp.sv
module blc_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    output logic         outside
);
    // equality with a limit is inside (R5)
    always_comb begin
        outside = (val > hi) || (val < lo);
    end
endmodule

// File: rtl/blc_fsm.sv
module blc_fsm
    import blc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       nib_stb,
    input  logic       done_stb,
    input  logic       en,
    input  logic       nib_out,
    input  logic       full_out,
    output logic       set_pulse,
    output blc_state_e state
);
    blc_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_NIB;
            ST_NIB: begin
                if (start)        nxt = ST_NIB;
                else if (nib_stb) nxt = nib_out ? ST_IDLE : ST_FULL;
            end
            ST_FULL: begin
                if (start)         nxt = ST_NIB;
                else if (done_stb) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        set_pulse = 1'b0;
        unique case (state)
            ST_IDLE: set_pulse = 1'b0;
            ST_NIB:  set_pulse = !start && nib_stb && nib_out && en;
            ST_FULL: set_pulse = !start && done_stb && full_out && en;
            default: set_pulse = 1'b0;
        endcase
    end

    // tracks sets since the last start, for checking only
    logic hit_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hit_seen <= 1'b0;
        else if (start)     hit_seen <= 1'b0;
        else if (set_pulse) hit_seen <= 1'b1;
    end

    assert_one_set_per_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_seen && !start |-> !set_pulse);
    assert_idle_strobes_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !set_pulse);
    assert_nib_leaves_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_NIB && nib_stb && !start |=> state != ST_NIB);
endmodule

// File: rtl/blc_window_irq.sv
module blc_window_irq
    import blc_pkg::*;
#(
    parameter int RES_W = 8,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic [RES_W-1:0] lim_hi,
    input  logic [RES_W-1:0] lim_lo,
    input  logic             chk_en,
    input  logic [RES_W-1:0] res_data,
    input  logic             nib_stb,
    input  logic             done_stb,
    input  logic             irq_clr,
    output logic             irq_flag
);
    localparam int NIB_LSB = RES_W - NIB_W;

    logic [RES_W-1:0] hi_q, lo_q;
    logic             nib_out, full_out, set_pulse, flag_q;
    blc_state_e       state;

    // shadow copies taken at start (R2)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '1;
            lo_q <= '0;
        end else if (conv_start) begin
            hi_q <= lim_hi;
            lo_q <= lim_lo;
        end
    end

    blc_cmp #(.W(NIB_W)) u_nib (
        .val     (res_data[RES_W-1:NIB_LSB]),
        .hi      (hi_q[RES_W-1:NIB_LSB]),
        .lo      (lo_q[RES_W-1:NIB_LSB]),
        .outside (nib_out)
    );

    blc_cmp #(.W(RES_W)) u_full (
        .val     (res_data),
        .hi      (hi_q),
        .lo      (lo_q),
        .outside (full_out)
    );

    blc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (conv_start),
        .nib_stb   (nib_stb),
        .done_stb  (done_stb),
        .en        (chk_en),
        .nib_out   (nib_out),
        .full_out  (full_out),
        .set_pulse (set_pulse),
        .state     (state)
    );

    // sticky flag, set beats clear (R8, R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (set_pulse) flag_q <= 1'b1;
        else if (irq_clr)   flag_q <= 1'b0;
    end

    assign irq_flag = flag_q;

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !irq_clr |=> irq_flag);
    assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr && !set_pulse |=> !irq_flag);
    assert_set_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |-> chk_en);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse && irq_clr |=> irq_flag);
    assert_rise_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(nib_stb || done_stb));
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> !irq_flag && state == ST_IDLE);
endmodule

// File: tb/sim_blc_window_irq.sv
module sim_blc_window_irq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start = 0, chk_en = 0, nib_stb = 0, done_stb = 0, irq_clr = 0;
    logic [7:0] lim_hi = 0, lim_lo = 0, res_data = 0;
    logic irq_flag;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    blc_window_irq u0 (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .chk_en(chk_en),
        .res_data(res_data), .nib_stb(nib_stb), .done_stb(done_stb),
        .irq_clr(irq_clr), .irq_flag(irq_flag)
    );

    // {hi, lo, result, expected flag}
    localparam logic [24:0] VEC [8] = '{
        {8'hC0, 8'h40, 8'h80, 1'b0},   // R4 inside
        {8'hC0, 8'h40, 8'hD0, 1'b1},   // R3 early high
        {8'hC0, 8'h40, 8'h30, 1'b1},   // R3 early low
        {8'hC5, 8'h40, 8'hC6, 1'b1},   // R4 nibble tie, full above
        {8'hC5, 8'h40, 8'hC5, 1'b0},   // R5 equal high
        {8'hC5, 8'h43, 8'h42, 1'b1},   // R4 full below
        {8'hC5, 8'h43, 8'h43, 1'b0},   // R5 equal low
        {8'hFF, 8'h00, 8'hFF, 1'b0}    // R5 full range
    };

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (irq_flag !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_flag=%0b expected=%0b", req, irq_flag, exp);
        end
    endtask

    task automatic tick; @(negedge clk); endtask

    task automatic clear_flag;
        irq_clr = 1; tick; irq_clr = 0; tick;
    endtask

    task automatic start_conv(input logic [7:0] h, input logic [7:0] l);
        lim_hi = h; lim_lo = l; conv_start = 1; tick; conv_start = 0;
    endtask

    task automatic pulse_nib(input logic [7:0] r);
        res_data = r; nib_stb = 1; tick; nib_stb = 0;
    endtask

    task automatic pulse_done(input logic [7:0] r);
        res_data = r; done_stb = 1; tick; done_stb = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: expired expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick; tick;
        check(1'b0, "R1");
        rst_n = 1; tick;
        check(1'b0, "R1");
        chk_en = 1;

        for (int i = 0; i < 8; i++) begin
            clear_flag;
            start_conv(VEC[i][24:17], VEC[i][16:9]);
            tick;
            pulse_nib(VEC[i][8:1]);
            tick;
            pulse_done(VEC[i][8:1]);
            check(VEC[i][0], "R3/R4/R5 vector");
        end

        // R3: early hit visible right after the nibble strobe
        clear_flag;
        start_conv(8'hC0, 8'h40);
        pulse_nib(8'hE0);
        check(1'b1, "R3 early timing");

        // R6: after an early hit, the final strobe is ignored
        clear_flag;
        check(1'b0, "R8 clear");
        pulse_done(8'hE0);
        check(1'b0, "R6 final skipped");

        // R2: limit changes during a conversion are ignored
        start_conv(8'hC0, 8'h40);
        lim_hi = 8'h10; lim_lo = 8'hF0;
        pulse_nib(8'h80);
        pulse_done(8'h80);
        check(1'b0, "R2 shadow limits");

        // R7: disabled check never sets the flag
        chk_en = 0;
        start_conv(8'hC0, 8'h40);
        pulse_nib(8'h80);
        pulse_done(8'hC1);
        check(1'b0, "R7 disabled full");
        start_conv(8'hC0, 8'h40);
        pulse_nib(8'hF0);
        check(1'b0, "R7 disabled early");
        chk_en = 1;

        // R8: flag survives a new start and idle cycles
        start_conv(8'hC0, 8'h40);
        pulse_nib(8'h00);
        start_conv(8'hC0, 8'h40);
        repeat (5) tick;
        check(1'b1, "R8 sticky");

        // R9: set and clear in the same cycle
        clear_flag;
        start_conv(8'hC0, 8'h40);
        res_data = 8'hF0; nib_stb = 1; irq_clr = 1; tick;
        nib_stb = 0; irq_clr = 0;
        check(1'b1, "R9 set wins");

        // R10: strobes while idle
        clear_flag;
        pulse_done(8'hFF);
        pulse_nib(8'hFF);
        tick;
        check(1'b0, "R10 idle strobes");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule